// File: doc/BRIEF.md
# Keyboard Matrix and Tape Input Port

This block answers CPU input reads on a single decoded I/O port. It keeps the pressed/released state of an eight-row key matrix in active-low row registers and reports that state together with the level of the cassette input line. The registers are updated by key events and require no scanning. Each event carries a row index and a column mask.

On a read of the port (address bit 0 low), the returned byte starts as all ones. Each row whose select bit in the upper address byte is low is ANDed into it, so several rows can be read at once. The tape level appears in the top data bit. A read of any address with bit 0 high returns all ones. The read result is registered: it appears at the clock edge that ends the read cycle and holds until the next read.

Top module: `kbd_tape_port`

## Requirements
- R1: After reset `rd_data` is 0xFF and every row register reads as 0xFF, meaning no key is down.
- R2: A read with `addr[0]` high returns 0xFF, whatever the key and tape state.
- R3: A read with `addr[0]` low starts from 0xFF and ANDs in row r for each r in 0..7 whose select bit `addr[8+r]` is low.
- R4: When several select bits are low, the result is the bitwise AND of all the selected rows.
- R5: A read with `addr[0]` low and `addr[15:8]` equal to 0xFF returns 0xFF in bits 6:0. Bit 7 follows the tape level.
- R6: On a read with `addr[0]` low, a low `tape_in` forces bit 7 of the result to 0. A high `tape_in` leaves bit 7 as the row merge gives it.
- R7: A key event with `key_pressed` = 1 clears, in the row named by `key_code[15:8]`, every bit set in the column mask `key_code[7:0]`.
- R8: A key event with `key_pressed` = 0 sets the masked bits of that row again. The other bits of the row and all other rows are unchanged.
- R9: A key event whose row index `key_code[15:8]` is 8 or more changes no row.
- R10: `rd_data` is loaded at the rising edge that ends a cycle with `io_rd` high, and holds in all other cycles. A read in the cycle after a key event sees that event. A read in the same cycle as the event sees the state before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by key events and CPU reads |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_rd | input | 1 | CPU I/O read strobe, one cycle per read |
| addr | input | 16 | CPU I/O address; bit 0 decodes the port and bits 15:8 select rows (active low) |
| rd_data | output | 8 | Registered read result |
| key_valid | input | 1 | Key event present this cycle |
| key_pressed | input | 1 | 1 = key down (clear bits), 0 = key up (set bits) |
| key_code | input | 16 | Row index in bits 15:8, column mask in bits 7:0 |
| tape_in | input | 1 | Cassette input level |

## Verification
A stale or corrupted row register cannot be seen until a read selects that row. Such a read shows the wrong value one edge after the read strobe, so the bench reads each row it has touched right after each event. Reads that select several rows are also checked, so that a merge which ORs rows or drops one is caught. An event decoded to the wrong row, or a truncated row index, shows up as a cleared bit in an unrelated row on the next whole-matrix read. A wrong read-data register shows as a value that changes on idle cycles or lags one read behind.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    // Number of matrix rows and columns of the default build
    localparam int KBD_ROWS = 8;
    localparam int KBD_COLS = 8;

    // Key event polarity
    typedef enum logic {
        KEY_UP   = 1'b0,
        KEY_DOWN = 1'b1
    } key_dir_e;
endpackage

// File: rtl/kbd_row_bank.sv
module kbd_row_bank
    import kbd_pkg::*;
#(
    parameter int ROWS  = KBD_ROWS,
    parameter int COLS  = KBD_COLS,
    parameter int IDX_W = KBD_COLS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       evt_valid,
    input  logic                       evt_pressed,
    input  logic [IDX_W-1:0]           evt_row,
    input  logic [COLS-1:0]            evt_mask,
    output logic [ROWS-1:0][COLS-1:0]  rows
);
    typedef struct packed {
        logic [ROWS-1:0][COLS-1:0] rows;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt_valid) begin
            for (int r = 0; r < ROWS; r++) begin
                // full-width compare: indices past the last row match nothing
                if (evt_row == IDX_W'(r)) begin
                    if (key_dir_e'(evt_pressed) == KEY_DOWN)
                        st_d.rows[r] = st_q.rows[r] & ~evt_mask;
                    else
                        st_d.rows[r] = st_q.rows[r] | evt_mask;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{rows: '1};
        else
            st_q <= st_d;
    end

    assign rows = st_q.rows;
endmodule

// File: rtl/kbd_read_merge.sv
module kbd_read_merge #(
    parameter int ROWS     = 8,
    parameter int COLS     = 8,
    parameter int TAPE_BIT = 7
) (
    input  logic                      port_hit_n,
    input  logic [ROWS-1:0]           row_sel_n,
    input  logic [ROWS-1:0][COLS-1:0] rows,
    input  logic                      tape_lvl,
    output logic [COLS-1:0]           merged
);
    always_comb begin
        merged = '1;
        if (!port_hit_n) begin
            for (int r = 0; r < ROWS; r++) begin
                if (!row_sel_n[r])
                    merged = merged & rows[r];
            end
            if (!tape_lvl)
                merged[TAPE_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/kbd_tape_port.sv
module kbd_tape_port
    import kbd_pkg::*;
#(
    parameter int ROWS     = KBD_ROWS,
    parameter int COLS     = KBD_COLS,
    parameter int ADDR_W   = 16,
    parameter int SEL_LSB  = 8,
    parameter int TAPE_BIT = COLS - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_rd,
    input  logic [ADDR_W-1:0]   addr,
    output logic [COLS-1:0]     rd_data,
    input  logic                key_valid,
    input  logic                key_pressed,
    input  logic [2*COLS-1:0]   key_code,
    input  logic                tape_in
);
    localparam int CODE_W = 2 * COLS;

    typedef struct packed {
        logic [COLS-1:0] rd;
    } port_t;

    port_t st_d, st_q;

    logic [ROWS-1:0][COLS-1:0] row_state;
    logic [COLS-1:0]           merged;
    logic                      unused_addr_bits;

    assign unused_addr_bits = ^addr[SEL_LSB-1:1];

    kbd_row_bank #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .IDX_W (CODE_W - COLS)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_valid   (key_valid),
        .evt_pressed (key_pressed),
        .evt_row     (key_code[CODE_W-1:COLS]),
        .evt_mask    (key_code[COLS-1:0]),
        .rows        (row_state)
    );

    kbd_read_merge #(
        .ROWS     (ROWS),
        .COLS     (COLS),
        .TAPE_BIT (TAPE_BIT)
    ) u_merge (
        .port_hit_n (addr[0]),
        .row_sel_n  (addr[SEL_LSB +: ROWS]),
        .rows       (row_state),
        .tape_lvl   (tape_in),
        .merged     (merged)
    );

    always_comb begin
        st_d = st_q;
        if (io_rd)
            st_d.rd = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{rd: '1};
        else
            st_q <= st_d;
    end

    assign rd_data = st_q.rd;
endmodule

// File: rtl/kbd_tape_port_chk.sv
module kbd_tape_port_chk #(
    parameter int ROWS     = 8,
    parameter int COLS     = 8,
    parameter int ADDR_W   = 16,
    parameter int SEL_LSB  = 8,
    parameter int TAPE_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_rd,
    input logic [ADDR_W-1:0] addr,
    input logic [COLS-1:0]   rd_data,
    input logic              tape_in
);
    logic unused_chk_bits;
    assign unused_chk_bits = ^addr[SEL_LSB-1:1];

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> rd_data == '1);

    // R2
    odd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && addr[0] |=> rd_data == '1);

    // R5
    no_row_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && !addr[0] && (addr[SEL_LSB +: ROWS] == '1) && tape_in
        |=> rd_data == '1);

    // R6
    tape_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && !addr[0] && !tape_in |=> !rd_data[TAPE_BIT]);

    // R10
    hold_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(rd_data));
endmodule

bind kbd_tape_port kbd_tape_port_chk #(
    .ROWS     (ROWS),
    .COLS     (COLS),
    .ADDR_W   (ADDR_W),
    .SEL_LSB  (SEL_LSB),
    .TAPE_BIT (TAPE_BIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_rd   (io_rd),
    .addr    (addr),
    .rd_data (rd_data),
    .tape_in (tape_in)
);

// File: tb/sim_kbd_tape_port.sv
`timescale 1ns/1ps
module sim_kbd_tape_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] addr = 16'hFFFF;
    logic [7:0]  rd_data;
    logic        key_valid = 1'b0;
    logic        key_pressed = 1'b0;
    logic [15:0] key_code = 16'h0000;
    logic        tape_in = 1'b1;

    int total = 0;
    int bad = 0;

    logic [7:0] model [8];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_at_edge = 1'b0;

    always #4 clk = ~clk;

    kbd_tape_port u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_rd       (io_rd),
        .addr        (addr),
        .rd_data     (rd_data),
        .key_valid   (key_valid),
        .key_pressed (key_pressed),
        .key_code    (key_code),
        .tape_in     (tape_in)
    );

    function automatic logic [7:0] expect_rd(logic [15:0] a, logic t);
        logic [7:0] v = 8'hFF;
        if (a[0]) return 8'hFF;
        for (int r = 0; r < 8; r++)
            if (!a[8+r]) v = v & model[r];
        if (!t) v[7] = 1'b0;
        return v;
    endfunction

    task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // driver: one cycle with optional key event and optional read
    task automatic step(bit do_key, bit pressed, logic [15:0] code,
                        bit do_rd, logic [15:0] a, logic t, string tag);
        @(negedge clk);
        if (do_rd) begin
            exp_q.push_back(expect_rd(a, t));
            tag_q.push_back(tag);
            io_rd = 1'b1;
            addr = a;
            tape_in = t;
        end
        if (do_key) begin
            if (code[15:8] < 8) begin
                if (pressed) model[code[10:8]] = model[code[10:8]] & ~code[7:0];
                else         model[code[10:8]] = model[code[10:8]] | code[7:0];
            end
            key_valid = 1'b1;
            key_pressed = pressed;
            key_code = code;
        end
        @(negedge clk);
        io_rd = 1'b0;
        key_valid = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic t, string tag);
        step(1'b0, 1'b0, 16'h0, 1'b1, a, t, tag);
    endtask

    task automatic key(bit pressed, logic [15:0] code);
        step(1'b1, pressed, code, 1'b0, 16'hFFFF, tape_in, "");
    endtask

    // monitor
    always @(posedge clk) rd_at_edge <= io_rd && rst_n;

    always @(negedge clk) begin
        if (rd_at_edge) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R10 actual=%02h expected=none (unexpected read)", rd_data);
            end else begin
                check(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++) model[r] = 8'hFF;
        repeat (3) @(negedge clk);
        check(rd_data, 8'hFF, "R1 reset value");
        rst_n = 1'b1;

        rd(16'h00FE, 1'b1, "R1 all rows released");

        key(1'b1, 16'h0001);
        rd(16'hFEFE, 1'b1, "R7 R3 row0 press");

        key(1'b1, 16'h0314);
        rd(16'hF7FE, 1'b1, "R7 row3 press");
        rd(16'hF6FE, 1'b1, "R4 rows0+3 merged");

        rd(16'hFEFF, 1'b1, "R2 odd address");
        rd(16'h0001, 1'b0, "R2 odd address tape low");

        rd(16'hFFFE, 1'b1, "R5 no row selected");
        rd(16'hFFFE, 1'b0, "R5 R6 no row tape low");
        rd(16'hFEFE, 1'b0, "R6 row0 tape low");

        key(1'b0, 16'h0304);
        rd(16'hF7FE, 1'b1, "R8 row3 partial release");
        rd(16'hFEFE, 1'b1, "R8 row0 untouched");

        key(1'b1, 16'h09FF);
        rd(16'h00FE, 1'b1, "R9 out-of-range row ignored");

        step(1'b1, 1'b1, 16'h0580, 1'b1, 16'hDFFE, 1'b1, "R10 same-cycle read sees old");
        rd(16'hDFFE, 1'b1, "R10 R7 next read sees event");

        @(negedge clk);
        addr = 16'h0000;
        tape_in = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_data, 8'h7F, "R10 hold without read");

        key(1'b1, 16'h07FF);
        rd(16'h7FFE, 1'b1, "R3 row7 all pressed");
        key(1'b0, 16'h07FF);
        rd(16'h7FFE, 1'b1, "R8 row7 all released");
        rd(16'h00FE, 1'b1, "R4 whole matrix");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R10 actual=%0d expected=0 pending reads", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule